// File: doc/BRIEF.md
# Infrared pulse-train text formatter

This block turns one captured infrared burst into one line of ASCII text. The burst sits in an external buffer as a list of duration words, counted in ticks of 1/16384 s. Each pair of words holds a mark (carrier on) followed by a space (carrier off). A start strobe and a pair count launch a pass over the buffer. The block looks at the first mark and the first space to sort the burst into one of three kinds: a consumer-remote data frame, a key-held repeat frame, or an unrecognised burst. It then streams the matching text line out, one byte per handshake.

A data frame prints a four-character header and then the bits carried by the space lengths, packed into bytes and shown as lowercase hex. A repeat frame prints a three-letter marker. An unrecognised burst prints every duration's low byte in hex. Every line ends with a carriage return and a line feed. The byte stream feeds a UART transmitter through a valid/ready pair.

Back-pressure rules: `tx_valid` depends only on internal state. While `tx_valid` is high and `tx_ready` is low, `tx_data` and `tx_valid` hold. A byte counts as taken on a rising clock edge where both are high. The consumer may hold `tx_ready` low for any length of time.

Top module: `ir_frame_texter`

## Requirements
- R1: When `start` is high while `busy` is low and `pair_count` is non-zero, `busy` is high from the next cycle. It stays high until the line-feed byte is accepted and is low in the cycle after that. A `start` while busy is ignored. `tx_valid` is never high while `busy` is low, and reset returns the block to idle with no output.
- R2: A `start` with `pair_count` equal to 0 produces no bytes and leaves `busy` low.
- R3: While `tx_valid` is high and `tx_ready` is low, `tx_data` and `tx_valid` stay unchanged. A byte is transferred on each edge where both are high.
- R4: A burst is a data frame when word 0 has a zero upper byte and a low byte from 144 to 150, and word 1 has a zero upper byte and a low byte from 70 to 76 (both windows inclusive). Its line starts with "NEC " (0x4e 0x45 0x43 0x20).
- R5: A burst with a valid leader as in R4 and a word 1 that has a zero upper byte and a low byte from 33 to 39 is a repeat frame. Its line is exactly "REP" followed by the terminator. Any further pairs are not read out.
- R6: Any other burst prints "RAW " and then, for every word index 0 to 2*pair_count-1 in order, the low byte as two lowercase hex digits (high nibble first) and a space.
- R7: In a data frame, pairs 1 to pair_count-1 each give one bit, taken from the low byte of the space word: below 18 gives 0, 18 or more gives 1. The mark words are not examined. Bits fill each byte from bit 0 upward. Each full byte prints as two lowercase hex digits (high nibble first) and a space. A trailing partial byte is dropped, and complementary bytes are not checked.
- R8: Every line, of every kind, ends with 0x0d followed by 0x0a.
- R9: The buffer port is read combinationally. Word 2k is the mark of pair k and word 2k+1 is its space. `rd_data` must reflect `rd_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch strobe, sampled while idle |
| pair_count | input | PCNT_W (7) | Number of mark/space pairs in the buffer |
| busy | output | 1 | High from launch until the line feed is accepted |
| rd_addr | output | IDX_W (8) | Buffer word index |
| rd_data | input | DUR_W (16) | Duration word at `rd_addr` |
| tx_data | output | 8 | Output character |
| tx_valid | output | 1 | `tx_data` holds a character |
| tx_ready | input | 1 | Consumer accepts the character |

## Verification
On every cycle, the assertions check the handshake hold rule, the absence of output while idle, the launch and empty-start behaviour of `busy`, that a line feed always follows a carriage return and ends the line, and that each emitted character comes from the small legal alphabet. Only the bench scenarios can show that the classification windows accept and reject at their exact edges. The same holds for the LSB-first bit packing with the 17/18 threshold, the dropping of a partial trailing byte, raw readout in word order, and immunity to a start issued mid-line, under both free-flowing and randomly stalled consumers.

// File: rtl/irfmt_pkg.sv
package irfmt_pkg;

  typedef enum logic [1:0] {
    KIND_RAW,
    KIND_DATA,
    KIND_RPT
  } frame_kind_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LEAD,
    ST_PAUSE,
    ST_HDR,
    ST_DATA,
    ST_RAW,
    ST_HEX,
    ST_CR,
    ST_LF
  } fmt_state_e;

  function automatic logic [7:0] nibble_ascii(input logic [3:0] n);
    if (n < 4'd10) return 8'h30 + {4'h0, n};
    else           return 8'h57 + {4'h0, n};
  endfunction

  function automatic logic [7:0] header_ascii(input frame_kind_e k, input logic [1:0] i);
    logic [7:0] c;
    c = 8'h20;
    case (k)
      KIND_RPT:  case (i) 2'd0: c = 8'h52; 2'd1: c = 8'h45; default: c = 8'h50; endcase
      KIND_DATA: case (i) 2'd0: c = 8'h4e; 2'd1: c = 8'h45; 2'd2: c = 8'h43; default: c = 8'h20; endcase
      default:   case (i) 2'd0: c = 8'h52; 2'd1: c = 8'h41; 2'd2: c = 8'h57; default: c = 8'h20; endcase
    endcase
    return c;
  endfunction

endpackage

// File: rtl/irfmt_window.sv
module irfmt_window #(
  parameter int DUR_W = 16,
  parameter int LO    = 0,
  parameter int HI    = 255
) (
  input  logic [DUR_W-1:0] word,
  output logic             hit
);
  localparam logic [7:0] LO_B = 8'(LO);
  localparam logic [7:0] HI_B = 8'(HI);

  always_comb begin
    hit = (word[DUR_W-1:8] == '0) && (word[7:0] >= LO_B) && (word[7:0] <= HI_B);
  end
endmodule

// File: rtl/irfmt_bit_packer.sv
module irfmt_bit_packer #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            shift,
  input  logic            bit_in,
  output logic            full,
  output logic [BITS-1:0] next_word
);
  localparam int CW = $clog2(BITS);

  logic [BITS-1:0] sh;
  logic [CW-1:0]   cnt;

  assign full      = (cnt == CW'(BITS - 1));
  assign next_word = {bit_in, sh[BITS-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '0;
      cnt <= '0;
    end else if (clr) begin
      sh  <= '0;
      cnt <= '0;
    end else if (shift) begin
      sh  <= next_word;
      cnt <= full ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ir_frame_texter.sv
module ir_frame_texter
  import irfmt_pkg::*;
#(
  parameter  int DUR_W     = 16,
  parameter  int MAX_PAIRS = 64,
  parameter  int LEAD_LO   = 144,
  parameter  int LEAD_HI   = 150,
  parameter  int HDR_LO    = 70,
  parameter  int HDR_HI    = 76,
  parameter  int RPT_LO    = 33,
  parameter  int RPT_HI    = 39,
  parameter  int BIT_SPLIT = 18,
  localparam int PCNT_W    = $clog2(MAX_PAIRS + 1),
  localparam int IDX_W     = PCNT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PCNT_W-1:0] pair_count,
  output logic              busy,
  output logic [IDX_W-1:0]  rd_addr,
  input  logic [DUR_W-1:0]  rd_data,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  input  logic              tx_ready
);
  localparam logic [7:0] SPLIT_B = 8'(BIT_SPLIT);

  fmt_state_e        state;
  frame_kind_e       kind;
  logic              lead_ok;
  logic [PCNT_W-1:0] npairs;
  logic [IDX_W-1:0]  idx;
  logic [1:0]        cidx;
  logic [7:0]        hbyte;
  logic              more_q;

  logic lead_hit, hdr_hit, rpt_hit;
  logic hs, hdr_last, more_now, pause_bit, pk_full;
  logic [7:0] pk_word;
  logic [IDX_W-1:0] end_idx;

  irfmt_window #(.DUR_W(DUR_W), .LO(LEAD_LO), .HI(LEAD_HI)) u_win_lead (.word(rd_data), .hit(lead_hit));
  irfmt_window #(.DUR_W(DUR_W), .LO(HDR_LO),  .HI(HDR_HI))  u_win_hdr  (.word(rd_data), .hit(hdr_hit));
  irfmt_window #(.DUR_W(DUR_W), .LO(RPT_LO),  .HI(RPT_HI))  u_win_rpt  (.word(rd_data), .hit(rpt_hit));

  assign pause_bit = (rd_data[7:0] >= SPLIT_B);

  irfmt_bit_packer #(.BITS(8)) u_packer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (state == ST_IDLE),
    .shift    (state == ST_DATA),
    .bit_in   (pause_bit),
    .full     (pk_full),
    .next_word(pk_word)
  );

  assign busy     = (state != ST_IDLE);
  assign tx_valid = (state == ST_HDR) || (state == ST_HEX) || (state == ST_CR) || (state == ST_LF);
  assign hs       = tx_valid && tx_ready;
  assign end_idx  = {npairs, 1'b0};
  assign more_now = ((idx + 1'b1) != end_idx);
  assign hdr_last = (kind == KIND_RPT) ? (cidx == 2'd2) : (cidx == 2'd3);

  always_comb begin
    case (state)
      ST_LEAD:  rd_addr = '0;
      ST_PAUSE: rd_addr = IDX_W'(1);
      default:  rd_addr = idx;
    endcase
  end

  always_comb begin
    case (state)
      ST_HDR:  tx_data = header_ascii(kind, cidx);
      ST_HEX:  tx_data = (cidx == 2'd0) ? nibble_ascii(hbyte[7:4]) :
                         (cidx == 2'd1) ? nibble_ascii(hbyte[3:0]) : 8'h20;
      ST_CR:   tx_data = 8'h0d;
      ST_LF:   tx_data = 8'h0a;
      default: tx_data = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      kind    <= KIND_RAW;
      lead_ok <= 1'b0;
      npairs  <= '0;
      idx     <= '0;
      cidx    <= '0;
      hbyte   <= '0;
      more_q  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start && (pair_count != '0)) begin
            npairs <= pair_count;
            state  <= ST_LEAD;
          end
        end
        ST_LEAD: begin
          lead_ok <= lead_hit;
          state   <= ST_PAUSE;
        end
        ST_PAUSE: begin
          if (lead_ok && hdr_hit)      kind <= KIND_DATA;
          else if (lead_ok && rpt_hit) kind <= KIND_RPT;
          else                         kind <= KIND_RAW;
          cidx  <= '0;
          state <= ST_HDR;
        end
        ST_HDR: begin
          if (hs) begin
            if (hdr_last) begin
              cidx <= '0;
              case (kind)
                KIND_RPT:  state <= ST_CR;
                KIND_DATA: begin
                  idx   <= IDX_W'(3);
                  state <= (npairs == PCNT_W'(1)) ? ST_CR : ST_DATA;
                end
                default: begin
                  idx   <= '0;
                  state <= ST_RAW;
                end
              endcase
            end else begin
              cidx <= cidx + 1'b1;
            end
          end
        end
        ST_DATA: begin
          idx <= idx + IDX_W'(2);
          if (pk_full) begin
            hbyte  <= pk_word;
            more_q <= more_now;
            cidx   <= '0;
            state  <= ST_HEX;
          end else if (!more_now) begin
            state <= ST_CR;
          end
        end
        ST_RAW: begin
          hbyte  <= rd_data[7:0];
          more_q <= more_now;
          idx    <= idx + 1'b1;
          cidx   <= '0;
          state  <= ST_HEX;
        end
        ST_HEX: begin
          if (hs) begin
            if (cidx == 2'd2) begin
              cidx <= '0;
              if (!more_q)                state <= ST_CR;
              else if (kind == KIND_DATA) state <= ST_DATA;
              else                        state <= ST_RAW;
            end else begin
              cidx <= cidx + 1'b1;
            end
          end
        end
        ST_CR:   if (hs) state <= ST_LF;
        ST_LF:   if (hs) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irfmt_checker.sv
module irfmt_checker #(
  parameter int PCNT_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [PCNT_W-1:0] pair_count,
  input logic              busy,
  input logic [7:0]        tx_data,
  input logic              tx_valid,
  input logic              tx_ready
);
  logic legal_char;
  always_comb begin
    legal_char = (tx_data == 8'h0d) || (tx_data == 8'h0a) || (tx_data == 8'h20) ||
                 (tx_data >= 8'h30 && tx_data <= 8'h39) ||
                 (tx_data >= 8'h61 && tx_data <= 8'h66) ||
                 (tx_data == 8'h4e) || (tx_data == 8'h45) || (tx_data == 8'h43) ||
                 (tx_data == 8'h52) || (tx_data == 8'h50) || (tx_data == 8'h41) ||
                 (tx_data == 8'h57);
  end

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tx_valid);

  assert_launch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && (pair_count != '0)) |=> busy);

  assert_empty_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && (pair_count == '0)) |=> !busy);

  assert_lf_after_cr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_data == 8'h0d) |=> (tx_valid && tx_data == 8'h0a));

  assert_line_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_data == 8'h0a) |=> !busy);

  assert_alphabet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> legal_char);
endmodule

bind ir_frame_texter irfmt_checker #(.PCNT_W(PCNT_W)) u_irfmt_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .pair_count(pair_count),
  .busy      (busy),
  .tx_data   (tx_data),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready)
);

// File: tb/ir_frame_texter_tb_top.sv
`timescale 1ns/1ps
module ir_frame_texter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [6:0] pair_count = '0;
  logic       busy;
  logic [7:0] rd_addr;
  logic [15:0] rd_data;
  logic [7:0] tx_data;
  logic       tx_valid;
  logic       tx_ready = 1'b1;

  always #5 clk = ~clk;

  logic [15:0] mem [0:255];
  assign rd_data = mem[rd_addr];

  ir_frame_texter dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .pair_count(pair_count), .busy(busy),
    .rd_addr(rd_addr), .rd_data(rd_data), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready)
  );

  typedef struct packed {
    logic [7:0]  ll;
    logic [7:0]  lh;
    logic [7:0]  pl;
    logic [7:0]  ph;
    logic [7:0]  np;
    logic [15:0] seed;
    logic        stall;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{8'd147, 8'd0, 8'd74, 8'd0, 8'd33, 16'hA55A, 1'b1},
    '{8'd144, 8'd0, 8'd70, 8'd0, 8'd5,  16'h000F, 1'b0},
    '{8'd150, 8'd0, 8'd76, 8'd0, 8'd10, 16'h01FF, 1'b1},
    '{8'd147, 8'd0, 8'd36, 8'd0, 8'd1,  16'h0000, 1'b0},
    '{8'd147, 8'd0, 8'd33, 8'd0, 8'd3,  16'hFFFF, 1'b1},
    '{8'd143, 8'd0, 8'd74, 8'd0, 8'd2,  16'h0001, 1'b0},
    '{8'd151, 8'd0, 8'd74, 8'd0, 8'd2,  16'h0003, 1'b1},
    '{8'd147, 8'd1, 8'd74, 8'd0, 8'd2,  16'h0000, 1'b0},
    '{8'd147, 8'd0, 8'd77, 8'd0, 8'd2,  16'h0000, 1'b1},
    '{8'd147, 8'd0, 8'd74, 8'd1, 8'd2,  16'h0000, 1'b0},
    '{8'd147, 8'd0, 8'd40, 8'd0, 8'd2,  16'h0000, 1'b0},
    '{8'd147, 8'd0, 8'd69, 8'd0, 8'd2,  16'h0002, 1'b1},
    '{8'd147, 8'd0, 8'd39, 8'd0, 8'd2,  16'h0000, 1'b0},
    '{8'd150, 8'd0, 8'd33, 8'd0, 8'd1,  16'h0000, 1'b1},
    '{8'd147, 8'd0, 8'd74, 8'd0, 8'd1,  16'h0000, 1'b0}
  };

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit stall_mode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  logic [7:0] cap_b [0:255];
  int cap_n = 0;
  logic [7:0] exp_b [0:255];
  int exp_n = 0;
  string exp_req;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected below %0d", cycles, 150000);
      finish_run();
    end
  end

  // ready driver and capture monitor, away from the rising edge
  initial begin
    bit prev_stall = 1'b0;
    logic [7:0] prev_data = '0;
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tx_ready = stall_mode ? lfsr[0] : 1'b1;
      #1;
      if (rst_n && prev_stall)
        chk(tx_valid && (tx_data == prev_data), "R3", "held byte", int'(tx_data), int'(prev_data));
      prev_stall = rst_n && tx_valid && !tx_ready;
      prev_data  = tx_data;
      if (rst_n && tx_valid && tx_ready && cap_n < 256) begin
        cap_b[cap_n] = tx_data;
        cap_n++;
      end
    end
  end

  task automatic push(input logic [7:0] c);
    exp_b[exp_n] = c;
    exp_n++;
  endtask

  task automatic push_hex(input logic [7:0] v);
    string hx;
    hx = "0123456789abcdef";
    push(hx[int'(v[7:4])]);
    push(hx[int'(v[3:0])]);
    push(8'h20);
  endtask

  task automatic fill(input vec_t v);
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    mem[0] = {v.lh, v.ll};
    mem[1] = {v.ph, v.pl};
    for (int k = 1; k < int'(v.np); k++) begin
      mem[2*k] = (k % 2 == 1) ? 16'h0009 : 16'h0008;
      if (v.seed[(k-1) % 16]) mem[2*k+1] = (k % 2 == 1) ? 16'd18 : 16'd26;
      else                    mem[2*k+1] = (k % 2 == 1) ? 16'd17 : 16'd8;
    end
  endtask

  // expected line from the requirement text
  task automatic model(input int np);
    bit lead_ok;
    logic [7:0] acc;
    int nb;
    exp_n = 0;
    lead_ok = (mem[0][15:8] == 0) && (mem[0][7:0] >= 144) && (mem[0][7:0] <= 150);
    if (lead_ok && mem[1][15:8] == 0 && mem[1][7:0] >= 70 && mem[1][7:0] <= 76) begin
      exp_req = "R4 R7";
      push("N"); push("E"); push("C"); push(" ");
      acc = '0; nb = 0;
      for (int k = 1; k < np; k++) begin
        acc[nb] = (mem[2*k+1][7:0] >= 18);
        nb++;
        if (nb == 8) begin
          push_hex(acc);
          acc = '0; nb = 0;
        end
      end
    end else if (lead_ok && mem[1][15:8] == 0 && mem[1][7:0] >= 33 && mem[1][7:0] <= 39) begin
      exp_req = "R5";
      push("R"); push("E"); push("P");
    end else begin
      exp_req = "R6 R9";
      push("R"); push("A"); push("W"); push(" ");
      for (int i = 0; i < 2*np; i++) push_hex(mem[i][7:0]);
    end
    push(8'h0d);
    push(8'h0a);
  endtask

  task automatic run_line(input int np);
    int guard;
    cap_n = 0;
    model(np);
    @(negedge clk);
    start = 1'b1;
    pair_count = 7'(np);
    @(negedge clk);
    start = 1'b0;
    #2;
    chk(busy == 1'b1, "R1", "busy after launch", int'(busy), 1);
    // a start while busy must be ignored
    @(negedge clk);
    start = 1'b1;
    pair_count = 7'd5;
    @(negedge clk);
    start = 1'b0;
    guard = 0;
    while (busy && guard < 4000) begin
      @(negedge clk);
      #2;
      guard++;
    end
    chk(!busy, "R1", "busy dropped", int'(busy), 0);
    chk(cap_n == exp_n, exp_req, "line length", cap_n, exp_n);
    for (int i = 0; i < exp_n && i < cap_n; i++)
      chk(cap_b[i] == exp_b[i], exp_req, $sformatf("byte %0d", i), int'(cap_b[i]), int'(exp_b[i]));
    if (cap_n >= 2) begin
      chk(cap_b[cap_n-2] == 8'h0d, "R8", "carriage return", int'(cap_b[cap_n-2]), 13);
      chk(cap_b[cap_n-1] == 8'h0a, "R8", "line feed", int'(cap_b[cap_n-1]), 10);
    end
    repeat (8) begin
      @(negedge clk);
      #2;
      chk(!busy && !tx_valid, "R1", "no second line", int'(busy | tx_valid), 0);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    repeat (3) @(negedge clk);
    chk(!busy, "R1", "busy in reset", int'(busy), 0);
    chk(!tx_valid, "R1", "valid in reset", int'(tx_valid), 0);
    rst_n = 1'b1;

    // table walk
    for (int v = 0; v < NV; v++) begin
      stall_mode = VECS[v].stall;
      fill(VECS[v]);
      run_line(int'(VECS[v].np));
    end
    stall_mode = 1'b0;

    // literal repeat line (R5)
    fill(VECS[3]);
    run_line(1);
    chk(cap_n == 5 && cap_b[0] == 8'h52 && cap_b[1] == 8'h45 && cap_b[2] == 8'h50,
        "R5", "repeat text", cap_n, 5);

    // literal data decode: 8 bits 1,0,1,1,0,0,0,0 -> 0x0d -> "0d " (R7)
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    mem[0] = 16'd147; mem[1] = 16'd74;
    mem[3] = 16'd40; mem[5] = 16'd3; mem[7] = 16'd18; mem[9] = 16'd200;
    mem[11] = 16'd17; mem[13] = 16'd0; mem[15] = 16'd10; mem[17] = 16'd1;
    run_line(9);
    chk(cap_n == 9 && cap_b[4] == "0" && cap_b[5] == "d", "R7", "lsb-first byte",
        int'(cap_b[5]), int'(8'h64));

    // empty packet (R2)
    cap_n = 0;
    @(negedge clk);
    start = 1'b1;
    pair_count = 7'd0;
    @(negedge clk);
    start = 1'b0;
    repeat (5) begin
      @(negedge clk);
      #2;
      chk(!busy && !tx_valid, "R2", "empty start quiet", int'(busy | tx_valid), 0);
    end
    chk(cap_n == 0, "R2", "empty start bytes", cap_n, 0);

    // reset in the middle of a line (R1)
    fill(VECS[0]);
    stall_mode = 1'b1;
    @(negedge clk);
    start = 1'b1;
    pair_count = 7'd33;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    #2;
    chk(!busy && !tx_valid, "R1", "reset mid-line", int'(busy | tx_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    stall_mode = 1'b0;
    fill(VECS[5]);
    run_line(2);

    finish_run();
  end
endmodule